// File: doc/BRIEF.md
# Video Word Fetch and Pixel Serializer

This block feeds a one-bit-per-pixel display from a frame buffer that sits in a 32 KB memory shared with a processor. The buffer holds 16-bit words. A video address counter and the memory address multiplexer together act as a single DMA channel. The block raises a request toward the memory arbiter and waits for a grant. While the grant is high it steers its own word address onto the shared address bus; at all other times the processor's address passes through. The returned word goes into a staging register. From there it is copied whole into a shift register whose most significant bit is the pixel output, so one pixel leaves the block on every clock of the active line.

A separate timing generator supplies three inputs: a frame-start strobe, a line-start strobe and a blank level. The line-start strobe arrives during horizontal blanking and starts a prefetch. The first word of the line is loaded into the shifter and the second into the staging register, so the first visible pixel comes straight from a full shifter. Each time the staging register is emptied into the shifter, the block issues the next fetch. That fetch then has one full word time (16 pixel clocks) to return.

Blank only takes effect on a word boundary. The last word of a line is therefore always shown in full. A line ends early only when blank is already high at a boundary, or when the next word has not arrived in time. The second case is recorded as a sticky underrun.

Top module: `pixel_fetch_serializer`

## Requirements
- R1: After reset, memReq, pixelOut and underrun are all 0.
- R2: memReq stays high until a cycle in which memGrant is high, then falls at the next edge. memAddr carries the video word address in every cycle where memGrant and memReq are both high, and carries cpuAddr in every other cycle.
- R3: The word on memData is captured in the cycle that follows the grant cycle. Values on memData in any other cycle are not used.
- R4: frameStart sets the video address to BASE_ADDR. Each grant advances it by one word. After WORDS_PER_LINE*LINES_PER_FRAME words it wraps back to BASE_ADDR even without a frameStart.
- R5: A lineStart pulse during blank triggers a prefetch of two words. When blank is then sampled low at a clock edge, the pixel shown in the following cycle is bit 15 of the first word of the line.
- R6: Pixels leave the block one per clock, bit 15 first, from words in ascending address order. A line shows exactly WORDS_PER_LINE*16 pixels. pixelOut is 0 during blank and at all other times outside those pixels.
- R7: When blank rises partway through a word, that word is still shown to its 16th pixel. When blank is high at a word boundary before the end of the line, output stops at that boundary.
- R8: At most one fetch is outstanding at a time, and at most WORDS_PER_LINE fetches are issued per line. After the prefetch, each new request is raised when the staging register is copied into the shifter.
- R9: If the staging register is empty at a word boundary inside an active line, underrun is set and pixelOut is 0 for the rest of the line. This happens when a fetch has not returned within 16 pixel clocks of its request. underrun stays set until frameStart clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame start strobe; rewinds the address and clears underrun |
| lineStart | input | 1 | Line start strobe during blank; starts the two-word prefetch |
| blank | input | 1 | Blank level from the timing generator |
| cpuAddr | input | ADDR_W | Processor word address passed to memory when the video channel is not granted |
| memGrant | input | 1 | Arbiter grant for the video request |
| memData | input | WORD_W | Memory read data, valid in the cycle after the grant |
| memReq | output | 1 | Video fetch request |
| memAddr | output | ADDR_W | Shared memory word address |
| pixelOut | output | 1 | Serial pixel output |
| underrun | output | 1 | Sticky flag: a word was missing at a boundary |

## Verification
The bench builds the block with four words per line, three lines per frame and a base address of 0x100. With a 12-word frame, the address wrap, several full frames and the last-word rule all fit in a short run. Grant latency is drawn at random between 0 and 9 cycles, which keeps each refill just inside the 16-clock window. A forced 25-cycle stall on the third word of a line drives the underrun path. Junk values on memData outside the data cycle, together with random processor addresses, expose any error in capture timing or in the address multiplexer.

// File: rtl/vidfetch_pkg.sv
package vidfetch_pkg;

  // Strobes from the control FSM to the datapath, one cycle each
  typedef struct packed {
    logic addrClear;   // rewind the video address to the buffer base
    logic addrInc;     // advance the video address by one word
    logic stageLoad;   // capture memory read data into the staging word
    logic shiftLoad;   // copy the staging word into the shifter
    logic shiftEn;     // shift one pixel out
    logic showPixel;   // pixel output is live (not blanked)
    logic selVideo;    // steer the video address onto the shared bus
  } fetchCtl_t;

endpackage

// File: rtl/vidfetch_datapath.sv
module vidfetch_datapath
  import vidfetch_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned BASE_ADDR   = 0,
  parameter int unsigned FRAME_WORDS = 16380
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchCtl_t         ctl,
  input  logic [WORD_W-1:0] memDataIn,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixelOut
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE_ADDR + FRAME_WORDS - 1);

  logic [ADDR_W-1:0] vidAddr;
  logic [WORD_W-1:0] stageWord;
  logic [WORD_W-1:0] shiftWord;

  // Video address counter with wrap at the end of the frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidAddr <= BASE_A;
    end else if (ctl.addrClear) begin
      vidAddr <= BASE_A;
    end else if (ctl.addrInc) begin
      vidAddr <= (vidAddr == LAST_A) ? BASE_A : vidAddr + 1'b1;
    end
  end

  // Staging word: decouples memory latency from the serializer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageWord <= '0;
    end else if (ctl.stageLoad) begin
      stageWord <= memDataIn;
    end
  end

  // Parallel-in serial-out shifter, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftWord <= '0;
    end else if (ctl.shiftLoad) begin
      shiftWord <= stageWord;
    end else if (ctl.shiftEn) begin
      shiftWord <= {shiftWord[WORD_W-2:0], 1'b0};
    end
  end

  assign memAddr  = ctl.selVideo ? vidAddr : cpuAddr;
  assign pixelOut = ctl.showPixel & shiftWord[WORD_W-1];

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrInc && !ctl.addrClear && (vidAddr != LAST_A) |=> vidAddr == $past(vidAddr) + 1'b1); // R4
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrInc && !ctl.addrClear && (vidAddr == LAST_A) |=> vidAddr == BASE_A); // R4
  AST_ADDR_REWIND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrClear |=> vidAddr == BASE_A); // R4

endmodule

// File: rtl/vidfetch_ctrl.sv
module vidfetch_ctrl
  import vidfetch_pkg::*;
#(
  parameter int unsigned WORD_W         = 16,
  parameter int unsigned WORDS_PER_LINE = 36
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      lineStart,
  input  logic      blank,
  input  logic      memGrant,
  output logic      memReq,
  output logic      underrun,
  output fetchCtl_t ctl
);

  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned CNT_W = $clog2(WORDS_PER_LINE + 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LINE_WRDS = CNT_W'(WORDS_PER_LINE);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS_PER_LINE - 1);

  logic             memReqQ;
  logic             dataDue;
  logic             stageValid;
  logic             shiftValid;
  logic             lineArmed;
  logic             lineActive;
  logic             underrunQ;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] fetched;
  logic [CNT_W-1:0] shown;

  logic grantTake, wordEnd, lastWord, endLine, refillAtEnd;
  logic initialLoad, shiftLoad, wantFetch, startShow, starve;

  always_comb begin
    grantTake   = memReqQ && memGrant;
    wordEnd     = lineActive && (bitCnt == LAST_BIT);
    lastWord    = (shown == LAST_WORD);
    starve      = wordEnd && !lastWord && !blank && !stageValid;
    endLine     = wordEnd && (lastWord || blank || !stageValid);
    refillAtEnd = wordEnd && !endLine;
    initialLoad = lineArmed && !lineActive && !shiftValid && stageValid;
    shiftLoad   = initialLoad || refillAtEnd;
    wantFetch   = shiftLoad && (fetched < LINE_WRDS);
    startShow   = lineArmed && !lineActive && shiftValid && !blank;
  end

  always_comb begin
    ctl.addrClear = frameStart;
    ctl.addrInc   = grantTake;
    ctl.stageLoad = dataDue;
    ctl.shiftLoad = shiftLoad;
    ctl.shiftEn   = lineActive;
    ctl.showPixel = lineActive;
    ctl.selVideo  = grantTake;
  end

  // Request/grant handshake and fetch bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReqQ <= 1'b0;
      dataDue <= 1'b0;
      fetched <= '0;
    end else begin
      dataDue <= grantTake;
      if (lineStart)      memReqQ <= 1'b1;
      else if (grantTake) memReqQ <= 1'b0;
      else if (wantFetch) memReqQ <= 1'b1;
      if (lineStart)      fetched <= '0;
      else if (grantTake) fetched <= fetched + 1'b1;
    end
  end

  // Staging and shifter occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      shiftValid <= 1'b0;
    end else if (lineStart) begin
      stageValid <= 1'b0;
      shiftValid <= 1'b0;
    end else begin
      if (dataDue)        stageValid <= 1'b1;
      else if (shiftLoad) stageValid <= 1'b0;
      if (endLine)          shiftValid <= 1'b0;
      else if (initialLoad) shiftValid <= 1'b1;
    end
  end

  // Line display state: blank only acts on a word boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineArmed  <= 1'b0;
      lineActive <= 1'b0;
      bitCnt     <= '0;
      shown      <= '0;
    end else if (lineStart) begin
      lineArmed  <= 1'b1;
      lineActive <= 1'b0;
      bitCnt     <= '0;
      shown      <= '0;
    end else begin
      if (endLine) begin
        lineArmed  <= 1'b0;
        lineActive <= 1'b0;
      end else if (startShow) begin
        lineActive <= 1'b1;
      end
      bitCnt <= lineActive ? bitCnt + 1'b1 : '0;
      if (wordEnd) shown <= shown + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           underrunQ <= 1'b0;
    else if (frameStart) underrunQ <= 1'b0;
    else if (starve)     underrunQ <= 1'b1;
  end

  assign memReq   = memReqQ;
  assign underrun = underrunQ;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqQ && !memGrant |=> memReqQ); // R2
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    memReqQ && memGrant && !lineStart |=> !memReqQ); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    dataDue |-> !memReqQ && !stageValid); // R8
  AST_FETCH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    memReqQ |-> fetched < LINE_WRDS); // R8
  AST_WORD_WHOLE: assert property (@(posedge clk) disable iff (!rstN)
    lineActive && (bitCnt != LAST_BIT) && !lineStart |=> lineActive); // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underrunQ && !frameStart |=> underrunQ); // R9

endmodule

// File: rtl/pixel_fetch_serializer.sv
module pixel_fetch_serializer
  import vidfetch_pkg::*;
#(
  parameter int unsigned WORD_W          = 16,
  parameter int unsigned ADDR_W          = 14,
  parameter int unsigned WORDS_PER_LINE  = 36,
  parameter int unsigned LINES_PER_FRAME = 455,
  parameter int unsigned BASE_ADDR       = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              blank,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              memGrant,
  input  logic [WORD_W-1:0] memData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              pixelOut,
  output logic              underrun
);

  localparam int unsigned FRAME_WORDS = WORDS_PER_LINE * LINES_PER_FRAME;

  fetchCtl_t ctl;

  vidfetch_ctrl #(
    .WORD_W        (WORD_W),
    .WORDS_PER_LINE(WORDS_PER_LINE)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .lineStart (lineStart),
    .blank     (blank),
    .memGrant  (memGrant),
    .memReq    (memReq),
    .underrun  (underrun),
    .ctl       (ctl)
  );

  vidfetch_datapath #(
    .WORD_W     (WORD_W),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .FRAME_WORDS(FRAME_WORDS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memDataIn(memData),
    .cpuAddr  (cpuAddr),
    .memAddr  (memAddr),
    .pixelOut (pixelOut)
  );

endmodule

// File: tb/pixel_fetch_serializer_tb.sv
module pixel_fetch_serializer_tb_top;

  localparam int WPL   = 4;
  localparam int LINES = 3;
  localparam int BASE  = 'h100;
  localparam int FRAME = WPL * LINES;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        lineStart = 1'b0;
  logic        blank = 1'b1;
  logic [13:0] cpuAddr = '0;
  logic        memGrant = 1'b0;
  logic [15:0] memData = '0;
  logic        memReq;
  logic [13:0] memAddr;
  logic        pixelOut;
  logic        underrun;

  int checks = 0;
  int failures = 0;
  int expAddr = BASE;
  int grantCount = 0;
  int stallAt = -1;
  bit arbOn = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pixel_fetch_serializer #(
    .WORD_W(16), .ADDR_W(14), .WORDS_PER_LINE(WPL),
    .LINES_PER_FRAME(LINES), .BASE_ADDR(BASE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .blank(blank), .cpuAddr(cpuAddr), .memGrant(memGrant), .memData(memData),
    .memReq(memReq), .memAddr(memAddr), .pixelOut(pixelOut), .underrun(underrun)
  );

  function automatic logic [15:0] pixWord(input int a);
    logic [15:0] v;
    v = 16'(a) * 16'h9E37 + 16'h5A3C;
    return v | 16'h0001;
  endfunction

  function automatic int wrapAddr(input int a);
    return BASE + ((a - BASE) % FRAME);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Arbiter and memory model: grant after a delay, data in the following cycle
  initial begin
    int waitCnt;
    int curDelay;
    int grantAddr;
    waitCnt = 0;
    curDelay = 0;
    grantAddr = 0;
    forever begin
      @(negedge clk);
      if (memGrant) begin
        memGrant = 1'b0;
        memData  = pixWord(grantAddr);       // R3: valid only in this cycle
      end else begin
        memData = 16'($urandom);             // junk outside the data cycle
        cpuAddr = 14'($urandom);
        if (arbOn && memReq) begin
          if (waitCnt == 0)
            curDelay = (grantCount == stallAt) ? 25 : int'($urandom % 10);
          if (waitCnt >= curDelay) begin
            memGrant = 1'b1;
            #1;
            grantAddr = int'(memAddr);
            chk("R2 R4 video address in grant cycle", grantAddr, expAddr);
            expAddr = wrapAddr(expAddr + 1);
            grantCount++;
            waitCnt = 0;
          end else begin
            waitCnt++;
            #1;
            chk("R2 processor address passes through", int'(memAddr), int'(cpuAddr));
          end
        end else begin
          #1;
          chk("R2 processor address passes through", int'(memAddr), int'(cpuAddr));
        end
      end
    end
  end

  task automatic pulseFrame();
    @(negedge clk);
    frameStart = 1'b1;
    expAddr = BASE;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // One line: prefetch in blank, then display; blank rises at blankAt
  task automatic playLine(input int blankAt, input int showWords, input string tag);
    int lineBase;
    lineBase = expAddr;
    @(negedge clk);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    repeat (40) begin
      @(negedge clk);
      chk({tag, " R6 zero during blank"}, int'(pixelOut), 0);
    end
    blank = 1'b0;
    for (int p = 0; p < WPL * 16 + 10; p++) begin
      int expBit;
      logic [15:0] w;
      @(negedge clk);
      w = pixWord(wrapAddr(lineBase + p / 16));
      expBit = (p < showWords * 16) ? int'(w[15 - (p % 16)]) : 0;
      if (p == 0) chk({tag, " R5 first pixel is bit15 of first word"}, int'(pixelOut), expBit);
      else if (p == WPL * 16 - 1 && showWords == WPL)
        chk({tag, " R7 last pixel of last word shown"}, int'(pixelOut), expBit);
      else chk({tag, " R6 pixel stream"}, int'(pixelOut), expBit);
      if (p == blankAt) blank = 1'b1;
    end
    blank = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (5) @(negedge clk);
    chk("R1 memReq after reset", int'(memReq), 0);
    chk("R1 pixelOut after reset", int'(pixelOut), 0);
    chk("R1 underrun after reset", int'(underrun), 0);
    rstN = 1'b1;
    arbOn = 1'b1;
    @(negedge clk);
    chk("R1 memReq idle", int'(memReq), 0);

    // Several full frames; blank rises in the middle of the last word
    for (int f = 0; f < 3; f++) begin
      pulseFrame();
      for (int l = 0; l < LINES; l++) playLine(WPL * 16 - 8, WPL, "frame");
    end
    // R4: no frameStart, the address wraps to the base by itself
    chk("R4 wrapped address", expAddr, BASE);
    playLine(WPL * 16 - 8, WPL, "R4 wrap line");
    // R7: blank raised mid-line ends output after the current word
    pulseFrame();
    playLine(2 * 16 + 5, 3, "R7 early blank");
    // Blank held low past line end: still exactly WPL words (R6)
    pulseFrame();
    playLine(WPL * 16 + 9, WPL, "R6 long active");
    chk("R9 no underrun on normal lines", int'(underrun), 0);
    // R9: third fetch stalled beyond the word window
    pulseFrame();
    stallAt = grantCount + 2;
    playLine(WPL * 16 - 8, 2, "R9 underrun");
    chk("R9 underrun set", int'(underrun), 1);
    repeat (40) @(negedge clk);
    chk("R9 underrun sticky", int'(underrun), 1);
    stallAt = -1;
    pulseFrame();
    @(negedge clk);
    chk("R9 underrun cleared by frameStart", int'(underrun), 0);
    chk("R8 no request left after frame start", int'(memReq), 0);
    playLine(WPL * 16 - 8, WPL, "R9 recovery");
    chk("R9 stays clear", int'(underrun), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule